// File: doc/BRIEF.md
# Edge-Driven Event Down-Counter

This block is a 16-bit down-counter that runs on the system clock but takes its count events from an asynchronous source. The source is either an external event pin or an internal real-time-clock signal. There is no prescaler in the path. The chosen source is brought into the clock domain through a synchronizer chain. An edge register then finds the selected transition, rising or falling. Each edge it finds takes one off the count.

While the block is disabled, the count follows the reload value. Once the block is enabled, the count steps down on each selected edge. When an edge arrives with the count already at zero, the count reloads from the reload value and the end-of-count interrupt flag is set. Software reads the identification register through a one-cycle read strobe, and that read clears the flag. If a new end-of-count event lands in the same cycle as the read, the flag stays set, so that event is not lost.

Top module: `evt_down_counter`

## Requirements
- R1: After reset the count output is 0 and the interrupt flag is 0.
- R2: While en_i is 0, the count takes the value of reload_i on each clock, and source edges do not change it.
- R3: With edge_sel_i = 0 (rising), each rising edge of the selected source lowers the count by one, and falling edges leave it unchanged.
- R4: With edge_sel_i = 1 (falling), each falling edge lowers the count by one, and rising edges leave it unchanged.
- R5: The count changes on the third rising clock edge after the source edge, and not earlier (default two synchronizer stages).
- R6: A counted edge that arrives while the count is 0 loads reload_i into the count and sets eoc_irq_o on the same clock.
- R7: A one-cycle id_rd_i pulse clears eoc_irq_o on that clock. Without a read, the flag stays set.
- R8: When a read and a new end-of-count event fall on the same clock, eoc_irq_o stays 1.
- R9: With src_sel_i = 1 the rtc_i input is counted and evt_pin_i is ignored. With src_sel_i = 0 the pin is counted and rtc_i is ignored.
- R10: A source that toggles on every clock, which puts the selected edge at half the clock rate, has every selected edge counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_pin_i | input | 1 | External event input, asynchronous |
| rtc_i | input | 1 | Internal real-time-clock signal, asynchronous |
| src_sel_i | input | 1 | Count source: 0 = pin, 1 = rtc |
| edge_sel_i | input | 1 | Counted edge: 0 = rising, 1 = falling |
| reload_i | input | 16 | Reload value |
| en_i | input | 1 | Counter enable |
| id_rd_i | input | 1 | Read strobe for the identification flag, which clears it |
| count_o | output | 16 | Current count |
| eoc_irq_o | output | 1 | End-of-count interrupt flag |

## Verification
A source edge driven just after a falling clock edge appears on count_o only after the third rising edge that follows. The bench therefore samples the count at the second falling edge, where it expects the old value, and at the third, where it expects the new one. The interrupt flag is set on the same rising edge that reloads the count, so it is checked at that same third falling edge. A read strobe held for one cycle takes effect on the next rising edge and is checked half a cycle later. Loading from reload_i while disabled takes one clock.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic {SRC_PIN = 1'b0, SRC_RTC = 1'b1} evc_src_e;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} evc_edge_e;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/evc_edge_det.sv
module evc_edge_det
  import evc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sig_i,
  input  evc_edge_e edge_sel_i,
  output logic      hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: hit_o = sig_i & ~prev_q;
      EDGE_FALL: hit_o = ~sig_i & prev_q;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/evc_down_cnt.sv
module evc_down_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eoc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i)              cnt_q <= reload_i;  // preload while stopped
    else if (hit_i && at_zero)   cnt_q <= reload_i;
    else if (hit_i)              cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;
  assign eoc_o = en_i & hit_i & at_zero;
endmodule

// File: rtl/evc_irq_flag.sv
module evc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q;

  // set beats read-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (flag_q & ~rd_i) | set_i;

  assign flag_o = flag_q;
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter
  import evc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_pin_i,
  input  logic             rtc_i,
  input  logic             src_sel_i,
  input  logic             edge_sel_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             en_i,
  input  logic             id_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             eoc_irq_o
);
  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_sync;
  logic               sel_sig;
  logic               hit;
  logic               eoc;

  assign src_raw[SRC_PIN] = evt_pin_i;
  assign src_raw[SRC_RTC] = rtc_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    evc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (src_raw[i]),
      .q_o    (src_sync[i])
    );
  end

  assign sel_sig = src_sync[src_sel_i];

  evc_edge_det i_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_i      (sel_sig),
    .edge_sel_i (evc_edge_e'(edge_sel_i)),
    .hit_o      (hit)
  );

  evc_down_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .hit_i    (hit),
    .reload_i (reload_i),
    .cnt_o    (count_o),
    .eoc_o    (eoc)
  );

  evc_irq_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (eoc),
    .rd_i   (id_rd_i),
    .flag_o (eoc_irq_o)
  );
endmodule

// File: rtl/evt_down_counter_chk.sv
module evt_down_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] reload_i,
  input logic             en_i,
  input logic             id_rd_i,
  input logic [CNT_W-1:0] count_o,
  input logic             eoc_irq_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  // R2
  disabled_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!en_i) |-> count_o == $past(reload_i));

  // R3
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(en_i) && count_o != $past(count_o) |->
      (count_o == $past(count_o) - CNT_W'(1)) ||
      ($past(count_o) == '0 && count_o == $past(reload_i)));

  // R6
  flag_set_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $rose(eoc_irq_o) |-> $past(count_o) == '0 && $past(en_i));

  // R7
  flag_clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $fell(eoc_irq_o) |-> $past(id_rd_i));

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(eoc_irq_o) && !$past(id_rd_i) |-> eoc_irq_o);
endmodule

bind evt_down_counter evt_down_counter_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reload_i  (reload_i),
  .en_i      (en_i),
  .id_rd_i   (id_rd_i),
  .count_o   (count_o),
  .eoc_irq_o (eoc_irq_o)
);

// File: tb/test_evt_down_counter.sv
`timescale 1ns/1ps
module test_evt_down_counter;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pin = 1'b0, rtc = 1'b0, src = 1'b0, edg = 1'b0, en = 1'b0, rd = 1'b0;
  logic [W-1:0] reload = '0;
  logic [W-1:0] cnt;
  logic         irq;
  int           checks = 0, fails = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  evt_down_counter i_evt_down_counter (
    .clk_i(clk), .rst_ni(rst_n), .evt_pin_i(pin), .rtc_i(rtc),
    .src_sel_i(src), .edge_sel_i(edg), .reload_i(reload), .en_i(en),
    .id_rd_i(rd), .count_o(cnt), .eoc_irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive one source to a level and wait until it has settled through the chain
  task automatic set_src(input bit use_rtc, input logic v);
    @(negedge clk);
    if (use_rtc) rtc = v; else pin = v;
    wait_n(3);
  endtask

  task automatic load(input logic [W-1:0] v);
    @(negedge clk); en = 1'b0; reload = v;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 count", cnt, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_disabled;
    @(negedge clk); en = 1'b0; reload = 16'h1234;
    @(negedge clk); check("R2 preload", cnt, 16'h1234);
    set_src(1'b0, 1'b1); set_src(1'b0, 1'b0);
    check("R2 edges ignored", cnt, 16'h1234);
    reload = 16'h0042;
    @(negedge clk); check("R2 follows reload", cnt, 16'h0042);
  endtask

  task automatic t_rise_latency;
    edg = 1'b0; src = 1'b0;
    load(16'd10);
    @(negedge clk); pin = 1'b1;
    wait_n(2); check("R5 no change before third edge", cnt, 10);
    wait_n(1); check("R5 change on third edge", cnt, 9);
    check("R3 rising decrements", cnt, 9);
    set_src(1'b0, 1'b0);
    check("R3 falling ignored", cnt, 9);
  endtask

  task automatic t_fall;
    edg = 1'b1;
    load(16'd5);
    set_src(1'b0, 1'b1);
    check("R4 rising ignored", cnt, 5);
    set_src(1'b0, 1'b0);
    check("R4 falling decrements", cnt, 4);
    edg = 1'b0;
  endtask

  task automatic t_zero_reload;
    load(16'd1);
    set_src(1'b0, 1'b1); set_src(1'b0, 1'b0);
    check("R6 reaches zero", cnt, 0);
    check("R6 no flag at zero", irq, 0);
    @(negedge clk); pin = 1'b1;
    wait_n(3);
    check("R6 reload", cnt, 1);
    check("R6 flag set", irq, 1);
    set_src(1'b0, 1'b0);
    wait_n(4);
    check("R7 flag held without read", irq, 1);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check("R7 read clears", irq, 0);
  endtask

  task automatic t_collision;
    load(16'd1);
    set_src(1'b0, 1'b1); set_src(1'b0, 1'b0);
    @(negedge clk); pin = 1'b1;
    wait_n(3);
    check("R8 first flag", irq, 1);
    set_src(1'b0, 1'b0);
    set_src(1'b0, 1'b1); set_src(1'b0, 1'b0);
    check("R8 at zero again", cnt, 0);
    @(negedge clk); pin = 1'b1;
    wait_n(2); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check("R8 set wins over read", irq, 1);
    set_src(1'b0, 1'b0);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check("R8 later read clears", irq, 0);
  endtask

  task automatic t_rtc;
    src = 1'b1;
    load(16'd20);
    set_src(1'b0, 1'b1); set_src(1'b0, 1'b0);
    check("R9 pin ignored on rtc", cnt, 20);
    set_src(1'b1, 1'b1); set_src(1'b1, 1'b0);
    check("R9 rtc counted", cnt, 19);
    src = 1'b0;
    load(16'd20);
    set_src(1'b1, 1'b1); set_src(1'b1, 1'b0);
    check("R9 rtc ignored on pin", cnt, 20);
  endtask

  task automatic t_max_rate;
    load(16'd100);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); pin = ~pin;
    end
    wait_n(4);
    check("R10 half-rate edges all counted", cnt, 92);
  endtask

  initial begin
    wait_n(3);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    wait_n(2);
    t_reset;
    t_disabled;
    t_rise_latency;
    t_fall;
    t_zero_reload;
    t_collision;
    t_rtc;
    t_max_rate;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule